// File: doc/BRIEF.md
# SSI slave transmit controller

This block drives the data line of the slave end of a synchronous serial link. A remote master supplies the serial clock. The block resynchronises that clock into the system clock domain and waits for the line to go low. It then sends one queued parallel word, most significant bit first, and moves one bit on each rising clock edge. A programmable number of system cycles delays every bit change from the edge that caused it. When the master's falling edge that latches the last bit arrives, the data line drops low for a programmable monoflop time. After that time the line goes high and the block is idle again.

Words come in through a one-entry valid/ready holding stage. In immediate mode a queued word goes out on the next frame. In trigger mode it also needs a global trigger pulse first. If no word is available when the master starts clocking, the frame carries all ones and an underrun pulse is raised. After the last bit, the block times the clock-high pause. A falling clock inside that window is reported as a master timing error and does not start a frame.

Top module: `ssi_slave_tx`

## Requirements
- R1: While idle and after reset, `sdata_o` is 1 and `busy_o` is 0. A frame starts on a falling `sclk_i` that has passed through a two-flop synchroniser.
- R2: The word is sent most significant bit first, one bit per rising `sclk_i`. The bit value is held until the next rising edge.
- R3: With bit delay `tv_i` = d, a bit change on `sdata_o` appears at the (3+d)-th system clock edge after `sclk_i` rises. At the (2+d)-th edge the previous value is still present.
- R4: The `sclk_i` fall that follows the last bit's rising edge drives `sdata_o` to 0 at the 3rd edge. With `tm_i` = m (m of 1 or more), `sdata_o` returns to 1 at the (3+m)-th edge after that fall.
- R5: `word_len_i` sets the frame length L, from 3 to 32. The value sent is `word_i[L-1:0]`, and bits at and above L are ignored.
- R6: After the last bit, a synchronised rising `sclk_i` opens a pause window of `tp_i` cycles. A falling `sclk_i` inside that window gives a one-cycle `timing_err_o` pulse. No frame starts, and the queued word stays queued.
- R7: With `trig_mode_i` = 1, a queued word is only sent after a `trig_i` pulse. A frame that starts before the trigger does not consume the word. With `trig_mode_i` = 0, a queued word is sent on the next frame.
- R8: `busy_o` is 1 from the frame start through the end of the monoflop time, and it returns to 0 in the same cycle that `sdata_o` returns high.
- R9: If no word is available at frame start, the frame sends all ones and `underrun_o` pulses for one cycle. Frames that send a queued word give no pulse.
- R10: `word_ready_o` and `empty_o` are 1 exactly when no word is held. A word is taken on a clock edge where `word_valid_i` and `word_ready_o` are both 1, and it is released when its frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_i | input | 32 | Word to send, right-aligned |
| word_valid_i | input | 1 | Word offered |
| word_ready_o | output | 1 | Holding stage free |
| word_len_i | input | 6 | Frame length in bits (3..32) |
| tv_i | input | 8 | Bit delay in system cycles |
| tm_i | input | 16 | Monoflop low time in system cycles |
| tp_i | input | 16 | Minimum clock-high pause in system cycles |
| trig_mode_i | input | 1 | 1: wait for trigger before sending the queued word |
| trig_i | input | 1 | Global trigger pulse |
| sclk_i | input | 1 | Serial clock from the master, asynchronous |
| sdata_o | output | 1 | Serial data to the master |
| busy_o | output | 1 | Frame in progress |
| empty_o | output | 1 | No word held |
| underrun_o | output | 1 | One-cycle pulse: frame started without a word |
| timing_err_o | output | 1 | One-cycle pulse: clock fell during the pause |

## Verification
The hardest case to reach is a master timing error: a clock fall inside the pause window. The window only opens after a complete frame and the rising edge that follows it. The bench finishes a full frame, lets the clock rise, holds it high for only a few cycles with a long `tp_i`, and then pulls it low. It checks that the error pulses, that the line stays high, and that the word queued meanwhile is still held and goes out intact on the next good frame. The exact bit-delay and monoflop edges are checked at fixed cycle offsets, counted from each clock transition, across a sweep of every word length with varied delays.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ssi_clk_sync.sv
module ssi_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  // q[STAGES-1] is the synchronised level, q[STAGES] its previous value
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= 1'b1;
    else         q[0] <= sclk_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b1;
      else         q[i] <= q[i-1];
    end
  end

  assign rise_o = q[STAGES-1] & ~q[STAGES];
  assign fall_o = ~q[STAGES-1] & q[STAGES];
endmodule

// File: rtl/ssi_word_queue.sv
module ssi_word_queue #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic         trig_mode_i,
  input  logic         trig_i,
  input  logic         take_i,
  output logic [W-1:0] word_o,
  output logic         avail_o,
  output logic         empty_o
);
  logic [W-1:0] hold_q;
  logic         vld_q;
  logic         trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      vld_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      if (valid_i && !vld_q) begin
        hold_q <= word_i;
        vld_q  <= 1'b1;
      end else if (take_i) begin
        vld_q  <= 1'b0;
      end
      if (!trig_mode_i || take_i) trig_q <= 1'b0;
      if (trig_mode_i && trig_i)  trig_q <= 1'b1;
    end
  end

  assign ready_o = ~vld_q;
  assign empty_o = ~vld_q;
  assign word_o  = hold_q;
  assign avail_o = vld_q & (~trig_mode_i | trig_q);

  AST_TAKE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !vld_q); // R10
  AST_TRIG_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && trig_mode_i) |-> trig_q); // R7
endmodule

// File: rtl/ssi_pause_mon.sv
module ssi_pause_mon #(
  parameter int TP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic [TP_W-1:0] tp_i,
  output logic            in_pause_o,
  output logic            err_o
);
  logic            arm_q;
  logic [TP_W-1:0] cnt_q;
  logic            err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= fall_i && (cnt_q != '0);
      if (arm_i) begin
        arm_q <= 1'b1;
      end else if (rise_i && arm_q) begin
        arm_q <= 1'b0;
        cnt_q <= tp_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - TP_W'(1);
      end
    end
  end

  assign in_pause_o = (cnt_q != '0);
  assign err_o      = err_q;

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q); // R6
endmodule

// File: rtl/ssi_tx_engine.sv
module ssi_tx_engine
  import ssi_tx_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6,
  parameter int TV_W     = 8,
  parameter int TM_W     = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                pause_i,
  input  logic                avail_i,
  input  logic [MAX_BITS-1:0] word_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [TV_W-1:0]     tv_i,
  input  logic [TM_W-1:0]     tm_i,
  output logic                take_o,
  output logic                arm_o,
  output logic                sdata_o,
  output logic                busy_o,
  output logic                underrun_o
);
  localparam logic [LEN_W-1:0] LenMin = LEN_W'(3);
  localparam logic [LEN_W-1:0] LenMax = LEN_W'(MAX_BITS);

  tx_state_e           state_q;
  logic [MAX_BITS-1:0] sh_q;
  logic [LEN_W-1:0]    cnt_q;
  logic                pend_q;
  logic                pend_bit_q;
  logic [TV_W-1:0]     dly_q;
  logic [TM_W-1:0]     tm_q;
  logic                sdata_q;
  logic                und_q;

  logic [LEN_W-1:0]    len_eff;
  logic [MAX_BITS-1:0] aligned;
  logic                start;
  logic                last_fall;

  always_comb begin
    len_eff = len_i;
    if (len_i < LenMin)      len_eff = LenMin;
    else if (len_i > LenMax) len_eff = LenMax;
  end

  assign aligned   = word_i << (LenMax - len_eff);
  assign start     = (state_q == ST_IDLE) && fall_i && !pause_i;
  assign last_fall = (state_q == ST_SHIFT) && fall_i && (cnt_q == len_eff);
  assign take_o    = start && avail_i;
  assign arm_o     = last_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sh_q       <= '1;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      pend_bit_q <= 1'b1;
      dly_q      <= '0;
      tm_q       <= '0;
      sdata_q    <= 1'b1;
      und_q      <= 1'b0;
    end else begin
      und_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            sh_q    <= avail_i ? aligned : '1;
            und_q   <= ~avail_i;
          end
        end
        ST_SHIFT: begin
          if (last_fall) begin
            state_q <= ST_HOLD;
            sdata_q <= 1'b0;
            pend_q  <= 1'b0;
            tm_q    <= tm_i;
          end else if (rise_i && (cnt_q != len_eff)) begin
            cnt_q <= cnt_q + LEN_W'(1);
            sh_q  <= sh_q << 1;
            if (tv_i == '0) begin
              sdata_q <= sh_q[MAX_BITS-1];
              pend_q  <= 1'b0;
            end else begin
              pend_q     <= 1'b1;
              pend_bit_q <= sh_q[MAX_BITS-1];
              dly_q      <= tv_i;
            end
          end else if (pend_q) begin
            // delayed bit update
            if (dly_q == TV_W'(1)) begin
              sdata_q <= pend_bit_q;
              pend_q  <= 1'b0;
            end else begin
              dly_q <= dly_q - TV_W'(1);
            end
          end
        end
        ST_HOLD: begin
          if (tm_q <= TM_W'(1)) begin
            state_q <= ST_IDLE;
            sdata_q <= 1'b1;
          end else begin
            tm_q <= tm_q - TM_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sdata_o    = sdata_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign underrun_o = und_q;

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> sdata_q); // R1
  AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> !sdata_q); // R4
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LenMax); // R5
  AST_NO_START_IN_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && fall_i && pause_i) |=> (state_q == ST_IDLE)); // R6
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy_o); // R8
  AST_UNDERRUN_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    und_q |-> ((state_q == ST_SHIFT) && (&sh_q))); // R9
endmodule

// File: rtl/ssi_slave_tx.sv
module ssi_slave_tx #(
  parameter int MAX_BITS    = 32,
  parameter int TV_W        = 8,
  parameter int TM_W        = 16,
  parameter int TP_W        = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MAX_BITS-1:0] word_i,
  input  logic                word_valid_i,
  output logic                word_ready_o,
  input  logic [LEN_W-1:0]    word_len_i,
  input  logic [TV_W-1:0]     tv_i,
  input  logic [TM_W-1:0]     tm_i,
  input  logic [TP_W-1:0]     tp_i,
  input  logic                trig_mode_i,
  input  logic                trig_i,
  input  logic                sclk_i,
  output logic                sdata_o,
  output logic                busy_o,
  output logic                empty_o,
  output logic                underrun_o,
  output logic                timing_err_o
);
  logic                rise, fall;
  logic                take, avail, arm, in_pause;
  logic [MAX_BITS-1:0] held_word;

  ssi_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  ssi_word_queue #(.W(MAX_BITS)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_i      (word_i),
    .valid_i     (word_valid_i),
    .ready_o     (word_ready_o),
    .trig_mode_i (trig_mode_i),
    .trig_i      (trig_i),
    .take_i      (take),
    .word_o      (held_word),
    .avail_o     (avail),
    .empty_o     (empty_o)
  );

  ssi_pause_mon #(.TP_W(TP_W)) u_pause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm),
    .rise_i     (rise),
    .fall_i     (fall),
    .tp_i       (tp_i),
    .in_pause_o (in_pause),
    .err_o      (timing_err_o)
  );

  ssi_tx_engine #(
    .MAX_BITS (MAX_BITS),
    .LEN_W    (LEN_W),
    .TV_W     (TV_W),
    .TM_W     (TM_W)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .fall_i     (fall),
    .pause_i    (in_pause),
    .avail_i    (avail),
    .word_i     (held_word),
    .len_i      (word_len_i),
    .tv_i       (tv_i),
    .tm_i       (tm_i),
    .take_o     (take),
    .arm_o      (arm),
    .sdata_o    (sdata_o),
    .busy_o     (busy_o),
    .underrun_o (underrun_o)
  );
endmodule

// File: tb/ssi_slave_tx_test.sv
module ssi_slave_tx_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [5:0]  word_len_i = 6'd8;
  logic [7:0]  tv_i = '0;
  logic [15:0] tm_i = 16'd1;
  logic [15:0] tp_i = 16'd10;
  logic        trig_mode_i = 1'b0;
  logic        trig_i = 1'b0;
  logic        sclk_i = 1'b1;
  logic        sdata_o, busy_o, empty_o, underrun_o, timing_err_o;

  int n_chk = 0;
  int n_fail = 0;
  int err_seen = 0;
  int und_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssi_slave_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .word_len_i(word_len_i), .tv_i(tv_i), .tm_i(tm_i),
    .tp_i(tp_i), .trig_mode_i(trig_mode_i), .trig_i(trig_i), .sclk_i(sclk_i),
    .sdata_o(sdata_o), .busy_o(busy_o), .empty_o(empty_o), .underrun_o(underrun_o),
    .timing_err_o(timing_err_o)
  );

  always @(negedge clk) if (rst_n) begin
    if (timing_err_o) err_seen++;
    if (underrun_o)   und_seen++;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic queue_word(input logic [31:0] w);
    while (!word_ready_o) @(negedge clk);
    word_i = w;
    word_valid_i = 1'b1;
    @(negedge clk);
    word_valid_i = 1'b0;
  endtask

  // One complete frame driven by the master; exp holds the expected len bits.
  task automatic run_frame(input int len, input logic [31:0] exp, input int pause_cyc);
    int h, lowlen, tv, tm;
    logic prev, b;
    tv = int'(tv_i);
    tm = (tm_i == 0) ? 1 : int'(tm_i);
    h = tv + 6;
    lowlen = (tm + 6 > h) ? tm + 6 : h;
    sclk_i = 1'b0;
    wait_n(h);
    chk(busy_o == 1'b1, "R8 busy in frame", busy_o, 1);
    prev = 1'b1;
    for (int k = len - 1; k >= 0; k--) begin
      b = exp[k];
      sclk_i = 1'b1;
      for (int j = 1; j <= h; j++) begin
        @(negedge clk);
        if (b != prev && j == 2 + tv) chk(sdata_o == prev, "R3 before delay", sdata_o, prev);
        if (b != prev && j == 3 + tv) chk(sdata_o == b, "R3 at delay", sdata_o, b);
      end
      chk(sdata_o == b, "R2 bit value", sdata_o, b);
      prev = b;
      sclk_i = 1'b0;
      if (k != 0) wait_n(h);
    end
    for (int j = 1; j <= lowlen; j++) begin
      @(negedge clk);
      if (j == 3) chk(sdata_o == 1'b0, "R4 low after last bit", sdata_o, 0);
      if (j == 2 + tm) begin
        chk(sdata_o == 1'b0, "R4 still low", sdata_o, 0);
        chk(busy_o == 1'b1, "R8 busy in monoflop", busy_o, 1);
      end
      if (j == 3 + tm) begin
        chk(sdata_o == 1'b1, "R4 high after monoflop", sdata_o, 1);
        chk(busy_o == 1'b0, "R8 idle after monoflop", busy_o, 0);
      end
    end
    sclk_i = 1'b1;
    wait_n(pause_cyc);
  endtask

  function automatic logic [31:0] len_mask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int e0, u0;
    logic [31:0] w;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1 R8 R10 reset state
    chk(sdata_o == 1'b1, "R1 reset sdata", sdata_o, 1);
    chk(busy_o == 1'b0, "R8 reset busy", busy_o, 0);
    chk(word_ready_o == 1'b1, "R10 reset ready", word_ready_o, 1);
    chk(empty_o == 1'b1, "R10 reset empty", empty_o, 1);
    chk(timing_err_o == 1'b0 && underrun_o == 1'b0, "R6 R9 reset flags", {timing_err_o, underrun_o}, 0);

    queue_word(32'hA5);
    chk(empty_o == 1'b0 && word_ready_o == 1'b0, "R10 held word", {empty_o, word_ready_o}, 0);

    // R5 sweep of every length; upper garbage bits must be ignored
    u0 = und_seen;
    e0 = err_seen;
    word_len_i = 6'd8;
    run_frame(8, 32'hA5, 18);
    for (int len = 3; len <= 32; len++) begin
      w = (32'h9E37_79B9 * len) ^ (32'h5A5A_0F0F * (len + 7));
      word_len_i = 6'(len);
      tv_i = 8'(len % 4);
      tm_i = 16'(1 + (len % 5) * 3);
      queue_word(w);
      run_frame(len, w & len_mask(len), int'(tp_i) + 8);
    end
    chk(und_seen == u0, "R9 no underrun with data", und_seen, u0);
    chk(err_seen == e0, "R6 no error on long pause", err_seen, e0);

    // R3 large delays
    tv_i = 8'd100; tm_i = 16'd2; word_len_i = 6'd8;
    queue_word(32'h0000_3C96);
    run_frame(8, 32'h96, 18);
    tv_i = 8'd255; word_len_i = 6'd4;
    queue_word(32'h5);
    run_frame(4, 32'h5, 18);

    // R4 long monoflop
    tv_i = 8'd1; tm_i = 16'd1000; word_len_i = 6'd3;
    queue_word(32'h6);
    run_frame(3, 32'h6, 18);
    tm_i = 16'd4;

    // R9 underrun
    u0 = und_seen;
    word_len_i = 6'd6;
    run_frame(6, 32'h3F, 18);
    chk(und_seen == u0 + 1, "R9 underrun pulse", und_seen, u0 + 1);

    // R7 trigger mode
    trig_mode_i = 1'b1;
    queue_word(32'h12);
    u0 = und_seen;
    run_frame(6, 32'h3F, 18);
    chk(und_seen == u0 + 1, "R7 no trigger underrun", und_seen, u0 + 1);
    chk(empty_o == 1'b0, "R7 word kept without trigger", empty_o, 0);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    run_frame(6, 32'h12, 18);
    chk(empty_o == 1'b1, "R7 word sent after trigger", empty_o, 1);
    trig_mode_i = 1'b0;

    // R6 short pause
    tp_i = 16'd40; word_len_i = 6'd5;
    e0 = err_seen;
    queue_word(32'h0B);
    run_frame(5, 32'h0B, 5);
    queue_word(32'h15);
    sclk_i = 1'b0;
    wait_n(10);
    chk(err_seen == e0 + 1, "R6 timing error pulse", err_seen, e0 + 1);
    chk(busy_o == 1'b0, "R6 no frame start", busy_o, 0);
    chk(sdata_o == 1'b1, "R6 line stays high", sdata_o, 1);
    chk(empty_o == 1'b0, "R6 word still queued", empty_o, 0);
    sclk_i = 1'b1;
    wait_n(60);
    run_frame(5, 32'h15, 48);
    chk(err_seen == e0 + 1, "R6 no error after full pause", err_seen, e0 + 1);

    summary();
    $finish;
  end
endmodule